// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block models a synchronous SRAM whose data phase always trails its command by the same two clock edges. Reads and writes therefore share one fixed pipeline, and a host can issue them in any mix, every cycle, with no idle bus slots between a read and a write. A command (address, direction, byte-lane selects) is captured on a rising edge. For a write, the lane data and parity are taken from the shared bus two edges later. For a read, the word is driven onto the same bus during the cycle that ends on that second edge.

An on-chip two-bit sequencer lets one loaded address produce four beats. Each beat's low address bits follow a linear (wrapping add) or interleaved (XOR) order, chosen by an asynchronous mode input. A hold input freezes the whole block. Three chip enables, a sleep input and an asynchronous output enable control whether new commands start and whether the bus is driven. A read that hits the word still waiting for its write data returns that data, merged lane by lane.

Top module: `zbt_sram`

## Requirements
- R1: A command sampled at rising edge k has its data phase in the cycle between edges k+1 and k+2. Read data is driven over that cycle, and write data is taken from the bus at edge k+2. Reads and writes may alternate on consecutive edges with no idle cycle.
- R2: While `hold` is high at a rising edge, no input is sampled and nothing changes: pipeline, sequencer, output word, bus drive state and array contents.
- R3: An edge with `load_n` low and any chip enable inactive (`sel_a_n` high, `sel_b` low or `sel_c_n` high) starts no operation and ends any burst, so later advance edges do nothing. Operations already captured still complete.
- R4: Two edges after an edge that captures no read (idle, deselect or write), the bus is not driven.
- R5: `load_n` high advances an active burst by one beat. Its address keeps the upper bits of the loaded address, and its low two bits are start+n mod 4 when `burst_ilv` is 0, or start XOR n when it is 1, with n = 1, 2, 3, 0, and so on. Beats keep the burst's original direction and ignore `write_n`. An advance with no active burst does nothing.
- R6: Lane i is bits 8i+7..8i of `dat` plus `par[i]`. It is written only if `byte_wr_n[i]` was low at the edge that captured that beat, and the selects are sampled on every beat.
- R7: `out_en_n` high removes the drive from the bus at once, without a clock edge, and does not disturb the pipeline.
- R8: While `sleep` is high, the bus is not driven, no new command is accepted and any burst ends. Array contents are kept.
- R9: A read captured on the edge after a write to the same address returns the new data in the lanes that write enables, and the older contents in the other lanes.
- R10: A synchronous reset (`rst` high at an edge) empties the pipeline and ends any burst. The bus is not driven after it.
- R11: `bus_drive` is high exactly when the block drives `dat`/`par`. It is never high in a cycle in which write data is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: freeze every register, ignore all synchronous inputs |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| write_n | input | 1 | Direction on load: low write, high read |
| byte_wr_n | input | LANES | Per-lane write selects, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request: blocks commands and bus drive |
| dat | inout | 8*LANES | Data lanes |
| par | inout | LANES | Parity bit per lane |
| bus_drive | output | 1 | High while the block drives the bus |

## Verification
The bench aims at the turnaround cases first. It alternates writes and reads every cycle, and it issues a read right after a partial-lane write to the same word. A design that reads the array before the write lands would return stale lanes, and one that drives early would collide with write data (caught through `bus_drive`). It runs bursts in both orders from unaligned starts, with `write_n` toggling on advance edges. A wrong wrap or direction shows up as mismatched data. Deselect, sleep and reset are applied in mid-burst, hold is applied across write and read windows, and the output enable is pulsed inside a read window. A block that kept advancing, lost a pending write, or moved under hold would diverge from the reference model on the next compare.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Direction carried by a captured command.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Bits per lane: eight data bits plus one parity bit.
    localparam int LANE_W = 9;
    localparam int BYTE_W = 8;

    // Sequencer state of a four-beat burst.
    typedef struct packed {
        logic       active;
        op_e        dir;
        logic [1:0] cnt;
        logic [1:0] start;
    } burst_t;

    // Low address bits of beat n for a burst starting at `start`.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] n,
                                               input logic       ilv);
        return ilv ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             sleep,
    input  logic             load_n,
    input  logic             write_n,
    input  logic             sel_ok,
    input  logic             ilv,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] ben_n,
    output op_e              s1_op,
    output logic [AW-1:0]    s1_addr,
    output logic [LANES-1:0] s1_ben
);

    localparam int HI_W = AW - 2;

    burst_t          bst;
    logic [HI_W-1:0] hi_q;
    logic [1:0]      nxt_cnt;
    op_e             load_dir;

    assign nxt_cnt  = bst.cnt + 2'd1;
    assign load_dir = write_n ? OP_RD : OP_WR;

    always_ff @(posedge clk) begin
        if (rst) begin
            bst     <= '0;
            hi_q    <= '0;
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_ben  <= '0;
        end else if (!hold) begin
            if (sleep) begin
                bst.active <= 1'b0;
                s1_op      <= OP_IDLE;
            end else if (!load_n) begin
                if (sel_ok) begin
                    bst.active <= 1'b1;
                    bst.dir    <= load_dir;
                    bst.cnt    <= 2'd0;
                    bst.start  <= addr[1:0];
                    hi_q       <= addr[AW-1:2];
                    s1_op      <= load_dir;
                    s1_addr    <= addr;
                    s1_ben     <= ~ben_n;
                end else begin
                    bst.active <= 1'b0;
                    s1_op      <= OP_IDLE;
                end
            end else if (bst.active) begin
                bst.cnt <= nxt_cnt;
                s1_op   <= bst.dir;
                s1_addr <= {hi_q, beat_offset(bst.start, nxt_cnt, ilv)};
                s1_ben  <= ~ben_n;
            end else begin
                s1_op <= OP_IDLE;
            end
        end
    end

    // R3: a deselected load captures nothing and ends the burst
    a_r3_deselect_blocks: assert property (@(posedge clk) disable iff (rst)
        (!hold && !sleep && !load_n && !sel_ok) |=> (s1_op == OP_IDLE && !bst.active));

    // R5: advance beats keep the burst direction
    a_r5_dir_kept: assert property (@(posedge clk) disable iff (rst)
        (!hold && !sleep && load_n && bst.active) |=> (s1_op == $past(bst.dir)));

    // R5: advance with no burst is a no-op
    a_r5_idle_advance: assert property (@(posedge clk) disable iff (rst)
        (!hold && !sleep && load_n && !bst.active) |=> (s1_op == OP_IDLE));

    // R8: sleep accepts no command
    a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        (!hold && sleep) |=> (s1_op == OP_IDLE && !bst.active));

endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        wlane,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int WW    = LANES * LANE_W;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wlane[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/zbt_merge.sv
module zbt_merge
    import zbt_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    hit,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] fresh,
    input  logic [LANES*LANE_W-1:0] stored,
    output logic [LANES*LANE_W-1:0] merged
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = (hit && lane_en[i])
                                          ? fresh[i*LANE_W +: LANE_W]
                                          : stored[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    load_n,
    input  logic                    write_n,
    input  logic [LANES-1:0]        byte_wr_n,
    input  logic                    burst_ilv,
    input  logic [AW-1:0]           addr,
    input  logic                    out_en_n,
    input  logic                    sleep,
    inout  wire  [LANES*BYTE_W-1:0] dat,
    inout  wire  [LANES-1:0]        par,
    output logic                    bus_drive
);

    localparam int WW = LANES * LANE_W;

    op_e              s1_op;
    logic [AW-1:0]    s1_addr;
    logic [LANES-1:0] s1_ben;

    op_e              s2_op;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s2_ben;

    logic             drive_q;
    logic [WW-1:0]    q_word;
    logic [WW-1:0]    bus_word;
    logic [WW-1:0]    arr_word;
    logic [WW-1:0]    rd_word;
    logic             sel_ok;
    logic             commit;
    logic             fwd_hit;

    assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;
    assign commit  = !rst && !hold && (s2_op == OP_WR);
    assign fwd_hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

    // Lane packing between the split bus and the stored word.
    for (genvar i = 0; i < LANES; i++) begin : g_bus
        assign bus_word[i*LANE_W +: LANE_W] = {par[i], dat[i*BYTE_W +: BYTE_W]};
        assign dat[i*BYTE_W +: BYTE_W] = bus_drive ? q_word[i*LANE_W +: BYTE_W] : 'z;
        assign par[i] = bus_drive ? q_word[i*LANE_W + BYTE_W] : 1'bz;
    end

    zbt_burst_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .sleep   (sleep),
        .load_n  (load_n),
        .write_n (write_n),
        .sel_ok  (sel_ok),
        .ilv     (burst_ilv),
        .addr    (addr),
        .ben_n   (byte_wr_n),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_ben  (s1_ben)
    );

    zbt_store #(.AW(AW), .LANES(LANES)) u_store (
        .clk   (clk),
        .we    (commit),
        .waddr (s2_addr),
        .wlane (s2_ben),
        .wdata (bus_word),
        .raddr (s1_addr),
        .rdata (arr_word)
    );

    zbt_merge #(.LANES(LANES)) u_merge (
        .hit     (fwd_hit),
        .lane_en (s2_ben),
        .fresh   (bus_word),
        .stored  (arr_word),
        .merged  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_ben  <= '0;
            drive_q <= 1'b0;
            q_word  <= '0;
        end else if (!hold) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_ben  <= s1_ben;
            drive_q <= (s1_op == OP_RD);
            if (s1_op == OP_RD) begin
                q_word <= rd_word;
            end
        end
    end

    assign bus_drive = drive_q && !out_en_n && !sleep;

    // R11: never drive while write data is due
    a_r11_quiet_in_write_window: assert property (@(posedge clk) disable iff (rst)
        (s2_op == OP_WR) |-> !bus_drive);

    // R2: hold freezes the data path
    a_r2_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(q_word) && $stable(drive_q) && $stable(s2_op) && $stable(s2_addr)));

    // R4: no read captured -> bus released two edges later
    a_r4_release_after_nonread: assert property (@(posedge clk) disable iff (rst)
        (!hold && s1_op != OP_RD) |=> !bus_drive);

    // R10: reset leaves the bus undriven
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !drive_q);

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;

    localparam int AW    = 6;
    localparam int LANES = 2;
    localparam int WW    = LANES * 9;
    localparam int DEPTH = 1 << AW;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             rst = 1'b1, hold = 1'b0, sleep = 1'b0, out_en_n = 1'b0, burst_ilv = 1'b0;
    logic             sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic             load_n = 1'b1, write_n = 1'b1;
    logic [LANES-1:0] byte_wr_n = '1;
    logic [AW-1:0]    addr = '0;
    logic             bus_drive;

    logic                 tb_drv = 1'b0;
    logic [WW-1:0]        tb_word = '0;
    wire  [LANES*8-1:0]   dat_w;
    wire  [LANES-1:0]     par_w;

    for (genvar i = 0; i < LANES; i++) begin : g_tbbus
        assign dat_w[i*8 +: 8] = tb_drv ? tb_word[i*9 +: 8] : 8'hzz;
        assign par_w[i]        = tb_drv ? tb_word[i*9 + 8]  : 1'bz;
    end

    zbt_sram #(.AW(AW), .LANES(LANES)) uut (
        .clk(clk), .rst(rst), .hold(hold),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .write_n(write_n), .byte_wr_n(byte_wr_n),
        .burst_ilv(burst_ilv), .addr(addr), .out_en_n(out_en_n), .sleep(sleep),
        .dat(dat_w), .par(par_w), .bus_drive(bus_drive)
    );

    // ---------------- reference model ----------------
    logic [WW-1:0] mmem [DEPTH];
    int            m_act = 0, m_dir = 0, m_cnt = 0, m_start = 0, m_hi = 0;
    int            s1op = 0, s1a = 0, s2op = 0, s2a = 0;
    logic [LANES-1:0] s1b = '0, s2b = '0;
    logic [WW-1:0] s1d = '0, s2d = '0, m_q = '0;
    int            m_drv = 0;
    int            seed = 1;

    int    checks = 0, fails = 0;
    string cur_req = "R10";

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] next_data();
        seed = (seed * 1103 + 12345) % 262144;
        return WW'(seed);
    endfunction

    task automatic model_edge();
        if (rst) begin
            s1op = 0; s2op = 0; m_drv = 0; m_act = 0;
        end else if (!hold) begin
            if (s2op == 2) begin
                for (int i = 0; i < LANES; i++)
                    if (s2b[i]) mmem[s2a][i*9 +: 9] = s2d[i*9 +: 9];
            end
            m_drv = (s1op == 1);
            if (s1op == 1) m_q = mmem[s1a];
            s2op = s1op; s2a = s1a; s2b = s1b; s2d = s1d;
            if (sleep) begin
                s1op = 0; m_act = 0;
            end else if (!load_n) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    m_act = 1; m_dir = write_n ? 1 : 2; m_cnt = 0;
                    m_start = int'(addr) % 4; m_hi = int'(addr) / 4;
                    s1op = m_dir; s1a = int'(addr); s1b = ~byte_wr_n; s1d = next_data();
                end else begin
                    m_act = 0; s1op = 0;
                end
            end else if (m_act != 0) begin
                int off;
                m_cnt = (m_cnt + 1) % 4;
                off = burst_ilv ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
                s1op = m_dir; s1a = m_hi * 4 + off; s1b = ~byte_wr_n; s1d = next_data();
            end else begin
                s1op = 0;
            end
        end
    endtask

    task automatic compare();
        logic [WW-1:0] obs;
        bit exp_drv;
        for (int i = 0; i < LANES; i++) obs[i*9 +: 9] = {par_w[i], dat_w[i*8 +: 8]};
        exp_drv = (m_drv != 0) && !out_en_n && !sleep;
        chk(bus_drive == exp_drv, "bus_drive", 32'(bus_drive), 32'(exp_drv));
        if (exp_drv) chk(obs == m_q, "read word", 32'(obs), 32'(m_q));
    endtask

    // One clock: compare, apply command pins, supply due write data, step model.
    task automatic put(input bit ld_n, input bit wr_n, input int a, input logic [1:0] bn, input int selc);
        @(negedge clk);
        compare();
        load_n = ld_n; write_n = wr_n; addr = AW'(a); byte_wr_n = bn;
        sel_a_n = (selc == 1); sel_b = (selc != 2); sel_c_n = (selc == 3);
        if (s2op == 2 && !rst) begin tb_drv = 1'b1; tb_word = s2d; end
        @(posedge clk);
        model_edge();
        #1 tb_drv = 1'b0;
    endtask

    task automatic nop(); put(1'b0, 1'b1, 0, 2'b11, 1); endtask
    task automatic adv(input bit wr_n, input logic [1:0] bn); put(1'b1, wr_n, 0, bn, 0); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        put(1'b0, 1'b1, 0, 2'b11, 1);
        put(1'b0, 1'b1, 0, 2'b11, 1);
        rst = 1'b0;
        nop();
        chk(bus_drive == 1'b0, "drive after reset", 32'(bus_drive), 0);

        // R1/R5: fill every word with linear write bursts; write_n toggles on advances
        cur_req = "R5";
        for (int b = 0; b < DEPTH / 4; b++) begin
            put(1'b0, 1'b0, b * 4, 2'b00, 0);
            adv(1'b1, 2'b00); adv(1'b0, 2'b00); adv(1'b1, 2'b00);
        end
        nop(); nop();

        // R5: linear read from unaligned start, write_n low on advances
        put(1'b0, 1'b1, 6, 2'b11, 0);
        adv(1'b0, 2'b00); adv(1'b0, 2'b00); adv(1'b0, 2'b00);
        adv(1'b0, 2'b00); // fifth beat wraps
        nop(); nop();

        // R5/R6: interleaved write with per-beat lane selects, then interleaved read
        cur_req = "R6";
        burst_ilv = 1'b1;
        put(1'b0, 1'b0, 9, 2'b10, 0);
        adv(1'b1, 2'b01); adv(1'b1, 2'b11); adv(1'b1, 2'b00);
        put(1'b0, 1'b1, 9, 2'b11, 0);
        adv(1'b1, 2'b11); adv(1'b1, 2'b11); adv(1'b1, 2'b11);
        cur_req = "R5";
        put(1'b0, 1'b1, 15, 2'b11, 0);
        adv(1'b1, 2'b11); adv(1'b1, 2'b11); adv(1'b1, 2'b11);
        burst_ilv = 1'b0;
        nop(); nop();

        // R1/R11: write/read alternation every cycle
        cur_req = "R1/R11";
        for (int k = 0; k < 8; k++) begin
            put(1'b0, 1'b0, 20 + k, 2'b00, 0);
            put(1'b0, 1'b1, 40 + k, 2'b11, 0);
        end
        nop(); nop();

        // R9: read right behind a partial write to the same word
        cur_req = "R9";
        put(1'b0, 1'b0, 33, 2'b10, 0);
        put(1'b0, 1'b1, 33, 2'b11, 0);
        put(1'b0, 1'b0, 34, 2'b01, 0);
        put(1'b0, 1'b1, 34, 2'b11, 0);
        nop(); nop();

        // R3/R4: deselect in mid burst, advances then idle
        cur_req = "R3/R4";
        put(1'b0, 1'b1, 12, 2'b11, 0);
        adv(1'b1, 2'b11);
        put(1'b0, 1'b1, 0, 2'b11, 2);
        adv(1'b1, 2'b11); adv(1'b1, 2'b11);
        put(1'b0, 1'b0, 16, 2'b00, 0);
        put(1'b0, 1'b0, 17, 2'b00, 3);
        adv(1'b0, 2'b00); adv(1'b0, 2'b00);
        nop(); nop();

        // R2: hold across a write window and across a read window
        cur_req = "R2";
        put(1'b0, 1'b0, 24, 2'b00, 0);
        hold = 1'b1;
        adv(1'b0, 2'b00); put(1'b0, 1'b1, 50, 2'b00, 0); adv(1'b0, 2'b00);
        hold = 1'b0;
        adv(1'b0, 2'b00);
        put(1'b0, 1'b1, 24, 2'b11, 0);
        nop();
        hold = 1'b1;
        nop(); nop(); nop();
        hold = 1'b0;
        nop(); nop();

        // R7: output enable pulsed inside a read window
        cur_req = "R7";
        put(1'b0, 1'b1, 7, 2'b11, 0);
        nop();
        @(negedge clk);
        compare();
        out_en_n = 1'b1;
        #1 chk(bus_drive == 1'b0, "drive with out_en_n high", 32'(bus_drive), 0);
        out_en_n = 1'b0;
        #1 chk(bus_drive == 1'b1, "drive restored", 32'(bus_drive), 1);
        @(posedge clk);
        model_edge();
        #1;
        nop(); nop();

        // R8: sleep blocks commands and drive, keeps contents
        cur_req = "R8";
        put(1'b0, 1'b1, 7, 2'b11, 0);
        sleep = 1'b1;
        put(1'b0, 1'b0, 7, 2'b00, 0);
        put(1'b0, 1'b1, 8, 2'b11, 0);
        adv(1'b1, 2'b00);
        sleep = 1'b0;
        nop();
        put(1'b0, 1'b1, 7, 2'b11, 0);
        adv(1'b1, 2'b11);
        nop(); nop();

        // R10: reset in mid burst
        cur_req = "R10";
        put(1'b0, 1'b1, 28, 2'b11, 0);
        adv(1'b1, 2'b11);
        rst = 1'b1;
        adv(1'b1, 2'b11);
        rst = 1'b0;
        adv(1'b1, 2'b11); adv(1'b1, 2'b11);
        nop();
        @(negedge clk);
        compare();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule